// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches 24 external interrupt pins and turns activity on each of them into a pending flag. Every pin has its own 4-bit trigger field. That field selects low level, high level, falling edge, rising edge or both edges. Any other code in the field disables the pin. Each pin also has a mask bit. A pending bit always records an event, but only an unmasked pending bit reaches an output.

The pending and unmasked sources are folded onto 6 lines that lead to a parent interrupt controller. Sources 0 to 3 each have a line of their own. Sources 4 to 7 share line 4, and sources 8 to 23 share line 5. When software handles a shared line, it reads the pending word, services the lowest set bit, and clears that bit by writing a 1 to it.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address. The register map is:

| Register | Address |
|---|---|
| Trigger word 0 (sources 0 to 7) | 0x88 |
| Trigger word 1 (sources 8 to 15) | 0x8C |
| Trigger word 2 (sources 16 to 23) | 0x90 |
| Mask | 0xA4 |
| Pending | 0xA8 |

Top module: `ext_irq_trigger_ctrl`

## Requirements
- R1: While reset is held and at the first cycle after it, the mask reads 0x00FFFFFF, the pending register reads 0, all three trigger words read 0, and all six outputs are low.
- R2: Source i has its trigger field at bits 4*(i mod 8)+3 down to 4*(i mod 8) of the word at address 0x88 + 4*(i div 8). A write replaces the whole word, and the written value reads back. Unmapped addresses read 0.
- R3: The edge codes are 2 (falling), 4 (rising) and 6 (either edge). In these modes a change of the synchronised pin sets the pending bit, and the bit stays set after the pin returns, until software clears it.
- R4: The level codes are 0 (low) and 1 (high). In these modes the pending bit is set on every cycle the synchronised pin is at the active level, so a clear does not stick while that level persists.
- R5: Trigger codes 3, 5, 7 and 8 to 15 never set pending, whatever the pin does.
- R6: The pending register is at 0xA8, with bit i for source i. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R7: The mask register is at 0xA4, with bits 23:0 readable and writable. A mask bit of 1 keeps its source off every output, but the pending bit is still recorded. A mask bit of 0 lets the source through.
- R8: Output k, for k from 0 to 3, is high exactly when source k is pending and unmasked.
- R9: Output 4 is the OR of pending-and-unmasked over sources 4 to 7. Output 5 is the same OR over sources 8 to 23.
- R10: When a detected event and a software clear land on the same pending bit in the same cycle, the bit ends up set.
- R11: Each pin passes through two synchroniser flops before detection. An event becomes visible in the pending register after the third rising clock edge following the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 24 | External interrupt pins (asynchronous) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| parentIrq | output | 6 | Lines to the parent interrupt controller |

## Verification
The hardest case to reach is a software clear of a pending bit that lands in the same cycle as a new hardware event on that bit. The event reaches the pending register only after the synchroniser and the edge register, so the stimulus changes an edge-mode pin and then holds a clear write on exactly the third clock edge after it. The bench then expects the bit to remain set. A long random phase adds more collisions, reserved trigger codes and partial masks, and it follows every edge with a cycle-level model of the register state.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int unsigned NUM_SRC      = 24;
  localparam int unsigned SRC_PER_WORD = 8;
  localparam int unsigned FIELD_W      = 4;
  localparam int unsigned CFG_WORDS    = NUM_SRC / SRC_PER_WORD;
  localparam int unsigned WORD_SEL_W   = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned NUM_DED      = 4;
  localparam int unsigned SHARED_SPLIT = 8;
  localparam int unsigned NUM_OUT      = NUM_DED + 2;

  localparam logic [ADDR_W-1:0] CFG_BASE  = 8'h88;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'hA4;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 8'hA8;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trigMode_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CFG,
    RD_MASK,
    RD_PEND
  } rdSel_e;

  typedef struct packed {
    logic [CFG_WORDS-1:0]  cfgWr;
    logic                  maskWr;
    logic                  pendClr;
    rdSel_e                rdSel;
    logic [WORD_SEL_W-1:0] rdWord;
  } ctrlStrobe_t;

  // Event test for one source: current and previous synchronised level
  function automatic logic trigHit(input logic [FIELD_W-1:0] mode,
                                   input logic cur, input logic prev);
    case (mode)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_FALL: return prev && !cur;
      TRIG_RISE: return !prev && cur;
      TRIG_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned WORDS     = CFG_WORDS,
  parameter logic [ADDR_BITS-1:0] CFG_ADDR0 = CFG_BASE,
  parameter logic [ADDR_BITS-1:0] MASK_AT   = MASK_ADDR,
  parameter logic [ADDR_BITS-1:0] PEND_AT   = PEND_ADDR
)(
  input  logic                 regWrEn,
  input  logic [ADDR_BITS-1:0] regAddr,
  output ctrlStrobe_t          strb
);

  logic [WORDS-1:0] cfgHit;
  logic             maskHit;
  logic             pendHit;

  for (genvar w = 0; w < WORDS; w++) begin : g_cfgDec
    localparam logic [ADDR_BITS-1:0] WORD_ADDR = ADDR_BITS'(CFG_ADDR0 + 4 * w);
    assign cfgHit[w] = (regAddr == WORD_ADDR);
  end

  assign maskHit = (regAddr == MASK_AT);
  assign pendHit = (regAddr == PEND_AT);

  always_comb begin
    strb         = '0;
    strb.cfgWr   = regWrEn ? cfgHit : '0;
    strb.maskWr  = regWrEn && maskHit;
    strb.pendClr = regWrEn && pendHit;
    strb.rdSel   = RD_NONE;
    strb.rdWord  = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (cfgHit[w]) begin
        strb.rdSel  = RD_CFG;
        strb.rdWord = WORD_SEL_W'(w);
      end
    end
    if (maskHit) strb.rdSel = RD_MASK;
    if (pendHit) strb.rdSel = RD_PEND;
  end

endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
#(
  parameter int unsigned NSRC     = NUM_SRC,
  parameter int unsigned PER_WORD = SRC_PER_WORD,
  parameter int unsigned FW       = FIELD_W,
  parameter int unsigned DW       = DATA_W
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] pinIn,
  input  ctrlStrobe_t     strb,
  input  logic [DW-1:0]   wrData,
  output logic [NSRC-1:0] pendQ,
  output logic [NSRC-1:0] maskQ,
  output logic [DW-1:0]   rdData
);

  localparam int unsigned WORDS     = NSRC / PER_WORD;
  localparam int unsigned WORD_BITS = PER_WORD * FW;

  logic [NSRC-1:0] sync1Q;
  logic [NSRC-1:0] sync2Q;
  logic [NSRC-1:0] prevQ;
  logic [NSRC-1:0] hitVec;
  logic [NSRC-1:0] clrVec;
  logic [WORDS-1:0][WORD_BITS-1:0] cfgQ;

  // Two-flop synchroniser plus one register of history for edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= pinIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (strb.cfgWr[w]) cfgQ[w] <= wrData[WORD_BITS-1:0];
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_detect
    localparam int unsigned WIDX = i / PER_WORD;
    localparam int unsigned SLOT = i % PER_WORD;
    logic [FW-1:0] mode;
    assign mode      = cfgQ[WIDX][SLOT*FW +: FW];
    assign hitVec[i] = trigHit(mode, sync2Q[i], prevQ[i]);
  end

  assign clrVec = strb.pendClr ? wrData[NSRC-1:0] : '0;

  // A detected event in the same cycle overrides a software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~clrVec) | hitVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strb.maskWr) begin
      maskQ <= wrData[NSRC-1:0];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_CFG:  rdData = DW'(cfgQ[strb.rdWord]);
      RD_MASK: rdData = DW'(maskQ);
      RD_PEND: rdData = DW'(pendQ);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/eint_group.sv
module eint_group
  import eint_pkg::*;
#(
  parameter int unsigned NSRC  = NUM_SRC,
  parameter int unsigned NDED  = NUM_DED,
  parameter int unsigned SPLIT = SHARED_SPLIT
)(
  input  logic [NSRC-1:0]   pendQ,
  input  logic [NSRC-1:0]   maskQ,
  output logic [NDED+1:0]   parentIrq
);

  logic [NSRC-1:0] live;

  assign live = pendQ & ~maskQ;

  for (genvar k = 0; k < NDED; k++) begin : g_dedicated
    assign parentIrq[k] = live[k];
  end

  assign parentIrq[NDED]   = |live[SPLIT-1:NDED];
  assign parentIrq[NDED+1] = |live[NSRC-1:SPLIT];

endmodule

// File: rtl/ext_irq_trigger_ctrl.sv
module ext_irq_trigger_ctrl
  import eint_pkg::*;
#(
  parameter int unsigned NSRC  = NUM_SRC,
  parameter int unsigned ABITS = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NOUT  = NUM_OUT
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  pinIn,
  input  logic             regWrEn,
  input  logic [ABITS-1:0] regAddr,
  input  logic [DW-1:0]    regWrData,
  output logic [DW-1:0]    regRdData,
  output logic [NOUT-1:0]  parentIrq
);

  ctrlStrobe_t     strb;
  logic [NSRC-1:0] pendQ;
  logic [NSRC-1:0] maskQ;

  eint_ctrl #(
    .ADDR_BITS(ABITS)
  ) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  eint_datapath #(
    .NSRC (NSRC),
    .DW   (DW)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .strb   (strb),
    .wrData (regWrData),
    .pendQ  (pendQ),
    .maskQ  (maskQ),
    .rdData (regRdData)
  );

  eint_group #(
    .NSRC (NSRC)
  ) u_group (
    .pendQ     (pendQ),
    .maskQ     (maskQ),
    .parentIrq (parentIrq)
  );

endmodule

// File: rtl/eint_checker.sv
module eint_checker
  import eint_pkg::*;
#(
  parameter int unsigned NSRC  = NUM_SRC,
  parameter int unsigned ABITS = ADDR_W,
  parameter int unsigned NOUT  = NUM_OUT
)(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [ABITS-1:0] regAddr,
  input logic [NSRC-1:0]  wrLow,
  input logic [NSRC-1:0]  pendQ,
  input logic [NSRC-1:0]  maskQ,
  input logic [NOUT-1:0]  parentIrq
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskQ == '1 && pendQ == '0 && parentIrq == '0));

  // R3/R6: without a clear write, no pending bit ever drops
  assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == PEND_ADDR) |=> (($past(pendQ) & ~pendQ) == '0));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == MASK_ADDR) |=> (maskQ == $past(wrLow)));

  assert_all_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1) |-> (parentIrq == '0));

  assert_shared_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    parentIrq[NOUT-1] |-> (|pendQ[NSRC-1:SHARED_SPLIT]));

endmodule

bind ext_irq_trigger_ctrl eint_checker #(
  .NSRC  (NSRC),
  .ABITS (ABITS),
  .NOUT  (NOUT)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .wrLow     (regWrData[NSRC-1:0]),
  .pendQ     (pendQ),
  .maskQ     (maskQ),
  .parentIrq (parentIrq)
);

// File: tb/ext_irq_trigger_ctrl_bench.sv
module ext_irq_trigger_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] pinIn = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  parentIrq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ext_irq_trigger_ctrl u_ext_irq_trigger_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .parentIrq (parentIrq)
  );

  // Reference state built from the requirements
  logic [23:0] mS1, mS2, mPrev, mPend, mMask, mHit;
  logic [31:0] mCfg [3];

  function automatic logic modeHit(logic [3:0] m, logic cur, logic prev);
    if (m == 4'd0) return !cur;
    if (m == 4'd1) return cur;
    if (m == 4'd2) return prev & !cur;
    if (m == 4'd4) return !prev & cur;
    if (m == 4'd6) return prev != cur;
    return 1'b0;
  endfunction

  always_comb begin
    for (int i = 0; i < 24; i++)
      mHit[i] = modeHit(mCfg[i / 8][(i % 8) * 4 +: 4], mS2[i], mPrev[i]);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0; mPend <= '0; mMask <= '1;
      mCfg[0] <= '0; mCfg[1] <= '0; mCfg[2] <= '0;
    end else begin
      mS1 <= pinIn; mS2 <= mS1; mPrev <= mS2;
      mPend <= (mPend & ~((regWrEn && regAddr == 8'hA8) ? regWrData[23:0] : 24'h0)) | mHit;
      if (regWrEn && regAddr == 8'hA4) mMask <= regWrData[23:0];
      if (regWrEn && regAddr == 8'h88) mCfg[0] <= regWrData;
      if (regWrEn && regAddr == 8'h8C) mCfg[1] <= regWrData;
      if (regWrEn && regAddr == 8'h90) mCfg[2] <= regWrData;
    end
  end

  function automatic logic [5:0] expIrq();
    logic [23:0] live;
    live = mPend & ~mMask;
    return {|live[23:8], |live[7:4], live[3:0]};
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h88: return mCfg[0];
      8'h8C: return mCfg[1];
      8'h90: return mCfg[2];
      8'hA4: return {8'h0, mMask};
      8'hA8: return {8'h0, mPend};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [7:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic irqChk(string req, logic [5:0] exp);
    #1;
    check(req, {26'h0, parentIrq}, {26'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    waitCyc(3);
    // R1: state while reset is held
    rdChk("R1 pend", 8'hA8, 32'h0);
    rdChk("R1 mask", 8'hA4, 32'h00FF_FFFF);
    rdChk("R1 cfg", 8'h8C, 32'h0);
    irqChk("R1 irq", 6'h0);
    rstN = 1'b1;
    waitCyc(5);
    // R4: mode 0 with low pins sets everything
    rdChk("R4 low-level fill", 8'hA8, 32'h00FF_FFFF);
    irqChk("R7 all masked", 6'h0);
    wrReg(8'h88, 32'h4444_4444);
    wrReg(8'h8C, 32'h4444_4444);
    wrReg(8'h90, 32'h4444_4444);
    wrReg(8'hA8, 32'h00FF_FFFF);
    waitCyc(4);
    rdChk("R6 clear all", 8'hA8, 32'h0);
    rdChk("R2 readback", 8'h8C, 32'h4444_4444);
    rdChk("R2 unmapped", 8'h40, 32'h0);
    // R3 rising edge on source 5; R11 latency
    pinIn[5] = 1'b1;
    waitCyc(2);
    rdChk("R11 not yet", 8'hA8, 32'h0);
    waitCyc(1);
    rdChk("R11 third edge", 8'hA8, 32'h20);
    irqChk("R7 masked pending", 6'h0);
    wrReg(8'hA4, 32'h00FF_FF0F);
    irqChk("R9 group4", 6'b010000);
    pinIn[5] = 1'b0;
    waitCyc(4);
    rdChk("R3 sticky", 8'hA8, 32'h20);
    wrReg(8'hA8, 32'h0);
    rdChk("R6 zero write", 8'hA8, 32'h20);
    wrReg(8'hA8, 32'h20);
    rdChk("R6 one write", 8'hA8, 32'h0);
    irqChk("R9 group4 idle", 6'h0);
    // R4 high level on source 2
    wrReg(8'h88, 32'h4444_4144);
    wrReg(8'hA4, 32'h00FF_FF0B);
    pinIn[2] = 1'b1;
    waitCyc(4);
    rdChk("R4 high", 8'hA8, 32'h4);
    irqChk("R8 line2", 6'b000100);
    wrReg(8'hA8, 32'h4);
    rdChk("R4 reset while active", 8'hA8, 32'h4);
    pinIn[2] = 1'b0;
    waitCyc(4);
    wrReg(8'hA8, 32'h4);
    rdChk("R4 clear after release", 8'hA8, 32'h0);
    // R5 reserved code on source 9
    wrReg(8'h8C, 32'h4444_4434);
    rdChk("R2 field replace", 8'h8C, 32'h4444_4434);
    pinIn[9] = 1'b1;
    waitCyc(4);
    pinIn[9] = 1'b0;
    waitCyc(4);
    rdChk("R5 reserved", 8'hA8, 32'h0);
    // R10: event and clear in the same cycle on source 12 (both edges)
    wrReg(8'h8C, 32'h4446_4434);
    wrReg(8'hA4, 32'h0);
    pinIn[12] = 1'b1;
    waitCyc(2);
    regWrEn = 1'b1; regAddr = 8'hA8; regWrData = 32'h1000;
    waitCyc(1);
    regWrEn = 1'b0;
    rdChk("R10 set wins", 8'hA8, 32'h1000);
    irqChk("R9 group5", 6'b100000);
    wrReg(8'hA8, 32'h1000);
    irqChk("R8 idle", 6'h0);
    pinIn[12] = 1'b0;
    waitCyc(4);
    rdChk("R3 both falling", 8'hA8, 32'h1000);
    wrReg(8'hA8, 32'h1000);
    // R3 falling only on source 20
    wrReg(8'h90, 32'h4442_4444);
    pinIn[20] = 1'b1;
    waitCyc(4);
    rdChk("R3 fall ignores rise", 8'hA8, 32'h0);
    pinIn[20] = 1'b0;
    waitCyc(4);
    rdChk("R3 falling", 8'hA8, 32'h0010_0000);
    irqChk("R9 group5 high src", 6'b100000);
    wrReg(8'hA8, 32'h0010_0000);
    // Random phase against the reference state
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      pinIn = pinIn ^ ($urandom & $urandom & $urandom & 32'h00FF_FFFF);
      case ($urandom % 6)
        0: regAddr = 8'h88;
        1: regAddr = 8'h8C;
        2: regAddr = 8'h90;
        3: regAddr = 8'hA4;
        4: regAddr = 8'hA8;
        default: regAddr = 8'h00;
      endcase
      regWrEn = ($urandom % 4) == 0;
      regWrData = $urandom;
      #1;
      check("R2 R6 R7 random read", regRdData, expRead(regAddr));
      check("R8 R9 random lines", {26'h0, parentIrq}, {26'h0, expIrq()});
    end
    @(negedge clk);
    regWrEn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule